// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

This block is a 16-bit timer/counter with a 16-bit companion register. It has two count sources. In timer function the count advances on every machine-cycle enable pulse. In event-counter function it advances on a high-to-low transition of an external count line. Both external lines, the count line and a trigger line, are sampled only on machine-cycle enable pulses. An edge is found by comparing the current sample with the sample taken on the previous enable pulse.

The companion register has a different role in each of the two modes. In capture mode, a sampled falling edge on the trigger line copies the live count into the companion register. In reload mode, the companion register holds the value that is loaded back into the count. The reload mode counts either upward or downward. Downward counting ends its period when the count meets the companion value. A sticky overflow flag and a sticky external-event flag are cleared only by rewriting the control register.

A byte-wide register port gives access to the count, the companion register and the control register. Writes through this port override any count activity in the same cycle.

Top module: `tmr16_capreload`

## Requirements
- R1: After a synchronous reset, the count, the companion register and the control register read as zero, and both flag outputs are low.
- R2: When the control register has run (bit 0) set and event select (bit 1) clear, the count increases by one on each cycle where `mc_tick` is high and holds on all other cycles. With run clear, the count holds.
- R3: When run and event select are both set, the count increases by one only on a `mc_tick` cycle where the previous sample of `ext_cnt_in` was 1 and the present sample is 0. Level changes between ticks are not seen. The sample register resets to 0.
- R4: In capture mode (bit 3 set), an advance from 0xFFFF gives 0x0000 and sets the overflow flag (control bit 6, output `ovf_flag`).
- R5: In capture mode with trigger enable (bit 2) set, a sampled falling edge on `ext_trg_in` copies the count value present before that cycle's advance into the companion register and sets the external flag (control bit 7, output `ext_flag`). With trigger enable clear, the edge changes nothing.
- R6: In reload mode (bit 3 clear) with down (bit 4) clear, an advance from 0xFFFF loads the companion value and sets the overflow flag.
- R7: In reload mode with down set, each advance decrements the count. An advance while the count equals the companion value loads 0xFFFF and sets the overflow flag.
- R8: In reload mode with trigger enable set, a sampled falling trigger edge loads the companion value into the count and sets the external flag. This takes priority over an advance in the same cycle.
- R9: A port write to a count byte takes effect in place of any advance in the same cycle, and the other count byte holds.
- R10: Register map, both for `wr_addr` and for `rd_addr`: address 0 is the count low byte, 1 the count high byte, 2 the companion low byte, 3 the companion high byte, 4 the control register. Addresses 5 to 7 read as zero.
- R11: Once set, a flag stays set until the control register is written. That write loads the flag bits from the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | Machine-cycle enable, one pulse per machine cycle |
| ext_cnt_in | input | 1 | External count line, already synchronous |
| ext_trg_in | input | 1 | External trigger line, already synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external-event flag |

## Verification
The assertions assume that both external lines are already synchronous to `clk` and change only between edges. They also assume that a write and a read never target the same register in a way that depends on ordering. The bench drives every input on the falling clock edge and changes `ext_cnt_in` and `ext_trg_in` only through its own drive tasks. The bench keeps its own copy of the last sampled level of each external line, so it knows at every `mc_tick` whether an edge is due. Level changes on cycles without a tick are injected on purpose, and the bench then expects no count.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

    parameter int CNT_W  = 16;
    parameter int BYTE_W = 8;
    parameter int ADDR_W = 3;
    parameter int NPINS  = 2;

    localparam int NB       = CNT_W / BYTE_W;
    localparam int CNT_BASE = 0;
    localparam int CAP_BASE = NB;
    localparam int CTL_ADDR = 2 * NB;
    localparam int PIN_CNT  = 0;
    localparam int PIN_TRG  = 1;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam cnt_t CNT_MAX = '1;

    typedef struct packed {
        logic ext_f;
        logic ovf_f;
        logic spare;
        logic down;
        logic cap_mode;
        logic trg_en;
        logic evt_sel;
        logic run;
    } ctrl_t;

    function automatic logic in_window(addr_t a, int base, int len);
        return (int'(a) >= base) && (int'(a) < base + len);
    endfunction

    function automatic byte_t byte_of(cnt_t v, int idx);
        return v[idx*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/tcr_edge.sv
module tcr_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic smp_q;

    always_ff @(posedge clk) begin
        if (rst)       smp_q <= 1'b0;
        else if (tick) smp_q <= pin;
    end

    assign fall = tick & smp_q & ~pin;

    // R3: the stored sample only moves on a tick
    p_sample_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(smp_q));
endmodule

// File: rtl/tcr_core.sv
module tcr_core
    import tcr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  cnt_fall,
    input  logic  trg_fall,
    input  logic  run,
    input  logic  evt_sel,
    input  logic  trg_en,
    input  logic  cap_mode,
    input  logic  down,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  byte_t wr_data,
    output cnt_t  cnt_q,
    output cnt_t  cap_q,
    output logic  ovf_set,
    output logic  ext_set
);
    logic step, trg_evt, cnt_wr, cap_wr, ovf_raw;
    cnt_t cnt_adv, cnt_d, cap_adv, cap_d;

    assign step    = run & tick & (evt_sel ? cnt_fall : 1'b1);
    assign trg_evt = trg_en & trg_fall;
    assign cnt_wr  = wr_en & in_window(wr_addr, CNT_BASE, NB);
    assign cap_wr  = wr_en & in_window(wr_addr, CAP_BASE, NB);

    always_comb begin
        cnt_adv = cnt_q;
        cap_adv = cap_q;
        ovf_raw = 1'b0;
        ext_set = 1'b0;
        if (cap_mode) begin
            if (trg_evt) begin
                cap_adv = cnt_q;
                ext_set = 1'b1;
            end
            if (step) begin
                cnt_adv = cnt_q + 1'b1;
                ovf_raw = (cnt_q == CNT_MAX);
            end
        end else if (trg_evt) begin
            cnt_adv = cap_q;
            ext_set = 1'b1;
        end else if (step) begin
            if (down) begin
                if (cnt_q == cap_q) begin
                    cnt_adv = CNT_MAX;
                    ovf_raw = 1'b1;
                end else begin
                    cnt_adv = cnt_q - 1'b1;
                end
            end else begin
                if (cnt_q == CNT_MAX) begin
                    cnt_adv = cap_q;
                    ovf_raw = 1'b1;
                end else begin
                    cnt_adv = cnt_q + 1'b1;
                end
            end
        end
    end

    assign ovf_set = ovf_raw & ~cnt_wr;

    always_comb begin
        cnt_d = cnt_wr ? cnt_q : cnt_adv;
        cap_d = cap_wr ? cap_q : cap_adv;
        for (int b = 0; b < NB; b++) begin
            if (wr_en && int'(wr_addr) == CNT_BASE + b) cnt_d[b*BYTE_W +: BYTE_W] = wr_data;
            if (wr_en && int'(wr_addr) == CAP_BASE + b) cap_d[b*BYTE_W +: BYTE_W] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cap_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            cap_q <= cap_d;
        end
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(cnt_q));

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (cap_mode && step && cnt_q == CNT_MAX && !cnt_wr) |=> (cnt_q == '0));

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (cap_mode && trg_evt && !cap_wr) |=> (cap_q == $past(cnt_q)));

    p_reload_up_r6: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode && !down && step && !trg_evt && cnt_q == CNT_MAX && !cnt_wr && !cap_wr)
        |=> (cnt_q == $past(cap_q)));

    p_reload_down_r7: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode && down && step && !trg_evt && cnt_q == cap_q && !cnt_wr)
        |=> (cnt_q == CNT_MAX));

    p_trg_load_r8: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode && trg_evt && !cnt_wr && !cap_wr) |=> (cnt_q == $past(cap_q)));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == addr_t'(CNT_BASE))
        |=> (cnt_q[BYTE_W-1:0] == $past(wr_data) && $stable(cnt_q[CNT_W-1:BYTE_W])));
endmodule

// File: rtl/tmr16_capreload.sv
module tmr16_capreload
    import tcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mc_tick,
    input  logic              ext_cnt_in,
    input  logic              ext_trg_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ovf_flag,
    output logic              ext_flag
);
    logic [NPINS-1:0] pins, falls;
    ctrl_t ctrl_q;
    cnt_t  cnt_q, cap_q;
    logic  ovf_set, ext_set, ctl_wr;

    assign pins[PIN_CNT] = ext_cnt_in;
    assign pins[PIN_TRG] = ext_trg_in;

    for (genvar g = 0; g < NPINS; g++) begin : g_smp
        tcr_edge u_edge (
            .clk  (clk),
            .rst  (rst),
            .tick (mc_tick),
            .pin  (pins[g]),
            .fall (falls[g])
        );
    end

    tcr_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (mc_tick),
        .cnt_fall (falls[PIN_CNT]),
        .trg_fall (falls[PIN_TRG]),
        .run      (ctrl_q.run),
        .evt_sel  (ctrl_q.evt_sel),
        .trg_en   (ctrl_q.trg_en),
        .cap_mode (ctrl_q.cap_mode),
        .down     (ctrl_q.down),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cnt_q    (cnt_q),
        .cap_q    (cap_q),
        .ovf_set  (ovf_set),
        .ext_set  (ext_set)
    );

    assign ctl_wr = wr_en && (int'(wr_addr) == CTL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctl_wr) begin
            ctrl_q <= ctrl_t'(wr_data);
        end else begin
            if (ovf_set) ctrl_q.ovf_f <= 1'b1;
            if (ext_set) ctrl_q.ext_f <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NB; b++) begin
            if (int'(rd_addr) == CNT_BASE + b) rd_data = byte_of(cnt_q, b);
            if (int'(rd_addr) == CAP_BASE + b) rd_data = byte_of(cap_q, b);
        end
        if (int'(rd_addr) == CTL_ADDR) rd_data = ctrl_q;
    end

    assign ovf_flag = ctrl_q.ovf_f;
    assign ext_flag = ctrl_q.ext_f;

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ctl_wr) |=> ovf_flag);

    p_ext_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (ext_flag && !ctl_wr) |=> ext_flag);

    p_ctl_load_r11: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctrl_q == $past(wr_data)));
endmodule

// File: tb/tmr16_capreload_tb_top.sv
module tmr16_capreload_tb_top;
    logic       clk = 1'b0, rst = 1'b1, mc_tick = 1'b0;
    logic       ext_cnt_in = 1'b0, ext_trg_in = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ovf_flag, ext_flag;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    tmr16_capreload dut_i (
        .clk(clk), .rst(rst), .mc_tick(mc_tick), .ext_cnt_in(ext_cnt_in),
        .ext_trg_in(ext_trg_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        mc_tick = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
    endtask

    task automatic wr16(input logic [2:0] a, input logic [15:0] v);
        wr(a, v[7:0]);
        wr(a + 3'd1, v[15:8]);
    endtask

    task automatic step(input logic t, input logic cp, input logic tp);
        @(negedge clk);
        wr_en = 1'b0; mc_tick = t; ext_cnt_in = cp; ext_trg_in = tp;
        @(posedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b0; mc_tick = 1'b0; rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 3'd1, hi);
        v = {hi, lo};
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) begin
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v, x, r, expc;
        logic        prev;
        logic [15:0] caps [3];
        logic [15:0] rels [3];
        caps[0] = 16'h0100; caps[1] = 16'h7FFE; caps[2] = 16'hFFFE;
        rels[0] = 16'h0000; rels[1] = 16'h1234; rels[2] = 16'h8000;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 / R10: reset contents and empty addresses
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), b);
            chk(a < 5 ? "R1 reset register" : "R10 unused address", {24'd0, b}, 32'd0);
        end
        chk("R1 ovf after reset", {31'd0, ovf_flag}, 32'd0);
        chk("R1 ext after reset", {31'd0, ext_flag}, 32'd0);

        // R2: timer function, ticks on two of every three cycles
        wr(3'd4, 8'h09);
        expc = 16'd0;
        for (int i = 0; i < 24; i++) begin
            step((i % 3) != 1, 1'b0, 1'b0);
            if ((i % 3) != 1) expc = expc + 16'd1;
            rd16(3'd0, v);
            chk("R2 timer count", {16'd0, v}, {16'd0, expc});
        end
        wr(3'd4, 8'h08);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
        rd16(3'd0, v);
        chk("R2 run clear holds", {16'd0, v}, {16'd0, expc});

        // R3: event counting with sampled falling edges
        wr16(3'd0, 16'h0000);
        wr(3'd4, 8'h0B);
        prev = 1'b0; expc = 16'd0;
        for (int i = 0; i < 32; i++) begin
            logic p, t;
            p = 1'(32'hB5C36A9E >> i);
            t = (i % 4) != 3;
            if (t) begin
                if (prev && !p) expc = expc + 16'd1;
                prev = p;
            end
            step(t, p, 1'b0);
            rd16(3'd0, v);
            chk("R3 event count", {16'd0, v}, {16'd0, expc});
        end
        // R3: a pulse between ticks is not seen
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        if (prev) expc = expc + 16'd1;
        rd16(3'd0, v);
        chk("R3 pulse between ticks ignored", {16'd0, v}, {16'd0, expc});

        // R4 / R11: wrap in capture mode and sticky flag
        wr16(3'd0, 16'hFFFD);
        wr(3'd4, 8'h09);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        rd16(3'd0, v);
        chk("R4 count before wrap", {16'd0, v}, 32'h0000FFFF);
        chk("R4 no ovf before wrap", {31'd0, ovf_flag}, 32'd0);
        step(1'b1, 1'b0, 1'b0);
        rd16(3'd0, v);
        chk("R4 wrap to zero", {16'd0, v}, 32'd0);
        chk("R4 ovf on wrap", {31'd0, ovf_flag}, 32'd1);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R11 ovf sticky", {31'd0, ovf_flag}, 32'd1);
        wr(3'd4, 8'h09);
        rd(3'd4, b);
        chk("R11 ovf cleared by control write", {31'd0, ovf_flag}, 32'd0);
        chk("R11 control readback", {24'd0, b}, 32'h09);

        // R5: capture on trigger edge
        for (int k = 0; k < 3; k++) begin
            x = caps[k];
            wr16(3'd0, x);
            wr(3'd4, 8'h0D);
            step(1'b1, 1'b0, 1'b1);
            step(1'b1, 1'b0, 1'b0);
            rd16(3'd2, v);
            chk("R5 captured value", {16'd0, v}, {16'd0, x + 16'd1});
            rd16(3'd0, v);
            chk("R5 count keeps running", {16'd0, v}, {16'd0, x + 16'd2});
            chk("R5 ext flag set", {31'd0, ext_flag}, 32'd1);
        end
        wr(3'd4, 8'h09);
        wr16(3'd2, 16'hAAAA);
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        rd16(3'd2, v);
        chk("R5 trigger disabled no capture", {16'd0, v}, 32'h0000AAAA);
        chk("R5 trigger disabled no ext flag", {31'd0, ext_flag}, 32'd0);

        // R6: up-count reload
        for (int k = 0; k < 3; k++) begin
            r = rels[k];
            wr16(3'd2, r);
            wr16(3'd0, 16'hFFFE);
            wr(3'd4, 8'h01);
            step(1'b1, 1'b0, 1'b0);
            rd16(3'd0, v);
            chk("R6 at top", {16'd0, v}, 32'h0000FFFF);
            chk("R6 no ovf yet", {31'd0, ovf_flag}, 32'd0);
            step(1'b1, 1'b0, 1'b0);
            rd16(3'd0, v);
            chk("R6 reload value", {16'd0, v}, {16'd0, r});
            chk("R6 ovf set", {31'd0, ovf_flag}, 32'd1);
            step(1'b1, 1'b0, 1'b0);
            rd16(3'd0, v);
            chk("R6 counts on from reload", {16'd0, v}, {16'd0, r + 16'd1});
        end

        // R7: down-count reload
        for (int k = 0; k < 3; k++) begin
            r = rels[k];
            wr16(3'd2, r);
            wr16(3'd0, r + 16'd2);
            wr(3'd4, 8'h11);
            step(1'b1, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            rd16(3'd0, v);
            chk("R7 down to reload value", {16'd0, v}, {16'd0, r});
            chk("R7 no ovf yet", {31'd0, ovf_flag}, 32'd0);
            step(1'b1, 1'b0, 1'b0);
            rd16(3'd0, v);
            chk("R7 load of top", {16'd0, v}, 32'h0000FFFF);
            chk("R7 ovf set", {31'd0, ovf_flag}, 32'd1);
            step(1'b1, 1'b0, 1'b0);
            rd16(3'd0, v);
            chk("R7 decrement from top", {16'd0, v}, 32'h0000FFFE);
        end

        // R8: trigger reload beats the advance
        wr16(3'd2, 16'h4321);
        wr16(3'd0, 16'h0010);
        wr(3'd4, 8'h05);
        step(1'b1, 1'b0, 1'b1);
        rd16(3'd0, v);
        chk("R8 advance before trigger", {16'd0, v}, 32'h00000011);
        step(1'b1, 1'b0, 1'b0);
        rd16(3'd0, v);
        chk("R8 trigger reload", {16'd0, v}, 32'h00004321);
        chk("R8 ext flag", {31'd0, ext_flag}, 32'd1);

        // R9: write beats advance in the same cycle
        wr(3'd4, 8'h09);
        wr16(3'd0, 16'h1280);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h55; mc_tick = 1'b1;
        @(posedge clk);
        rd16(3'd0, v);
        chk("R9 write wins over advance", {16'd0, v}, 32'h00001255);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'hA0; mc_tick = 1'b1;
        @(posedge clk);
        rd16(3'd0, v);
        chk("R9 high write holds low byte", {16'd0, v}, 32'h0000A055);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule